// File: doc/BRIEF.md
# Card Control Register Bank for a Four-Channel Acquisition Board

This block is the byte-wide control port of a four-channel pulse-height acquisition card that sits on a bus with 16-bit I/O addressing. It responds only on odd byte addresses. A card is picked out by comparing the upper address byte with a set of crate-wide main-address switches, and address bits 7:3 with per-card sub-address switches. Each switch reads as logic 0 when it is in its ON position.

There are four registers:
- A run register that every card sharing the main address accepts, so that all of them start and stop together.
- A control/status register.
- An 8-bit virtual station number.
- A mode-select register that enables each channel for singles and/or coincidence acquisition.

A control write can also launch a background clear of one channel's histogram memory. The clear writes zero to every 32-bit word of that channel's region, one word per cycle. Its progress is visible in the status byte, and a master reset aborts it.

Top module: `sio_ctrl_regs`

## Requirements
- R1: A write or read with address bit 0 low has no effect: no register changes and read data stays 0.
- R2: Offsets 3, 5 and 7 (address bits 2:1 = 01, 10, 11) respond only when address bits 15:8 equal the inverted main switches and address bits 7:3 equal the inverted sub switches. A switch input of 1 means ON, which is logic 0.
- R3: A write with address bits 2:1 = 00 needs only the main-address match. Data bit 0 sets singles run (1) or halt (0), and data bit 1 sets coincidence run (1) or halt (0).
- R4: A control write (offset 3) stores the channel select from D1:D0 (00 = channel 1 through 11 = channel 4), the scale mode from D3:D2 and the gate source from D4 (1 = VME). D5 is ignored.
- R5: Status D2 is 1 only for scale code 01 (forced to zero), and D3 is 1 only for code 10 (forced to full). Codes 00 and 11 both mean normal operation.
- R6: A write at offset 5 loads the 8-bit station number.
- R7: A write at offset 7 loads the coincidence enables of channels 1..4 from D3:D0 and the singles enables of channels 1..4 from D7:D4.
- R8: A control write with D7=1 and D6=0 starts a clear of the selected channel. Starting on the following cycle, one write per cycle goes to word address {channel, index}, with index counting 0 to 4095 in order. Status D7 reads 1 until the last write has been issued.
- R9: A clear start that arrives while a clear is running is ignored and does not change the channel being cleared.
- R10: A control write with D6=1 clears every register and both run bits, aborts any clear in progress, and raises master_rst for exactly one cycle.
- R11: A read at the card's offset 3 returns the status byte: D0 is the singles enable and D1 the coincidence enable of the selected channel, D4 is the gate source, and D6:D5 are 0. Every other read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe |
| main_sw_on | input | 8 | Main-address switches, 1 = ON |
| sub_sw_on | input | 5 | Sub-address switches, 1 = ON |
| rd_data | output | 8 | Read data, combinational |
| singles_run | output | 1 | Singles acquisition running |
| coinc_run | output | 1 | Coincidence acquisition running |
| sel_chan | output | 2 | Selected channel (0 = channel 1) |
| scale_mode | output | 2 | Sliding-scale mode code |
| gate_vme | output | 1 | Gate source, 1 = VME gate |
| vsn | output | 8 | Station number |
| coinc_en | output | 4 | Per-channel coincidence enables |
| singles_en | output | 4 | Per-channel singles enables |
| master_rst | output | 1 | One-cycle master reset pulse |
| ram_clr_we | output | 1 | Histogram clear write enable |
| ram_clr_addr | output | 14 | Histogram clear word address |

## Verification
The bench concentrates on address qualification. It sends writes with one bad sub-address, with a bad main address and with an even address. A decoder that ignored the sub-address, or that swapped the polarity of the switches, would corrupt the station number or the mode register. Shared run writes are sent with arbitrary sub-address bits; a card that also demanded a sub-address match would fail to start. The background clear is checked write by write against a queue of expected addresses. An off-by-one, a wrong channel field or a retargeting on a second start shows up as a mismatch, an extra write or a missing write. A master reset part way through a clear must stop the writes at once, so any write after it is an unexpected item.

// File: rtl/sio_ctrl_pkg.sv
package sio_ctrl_pkg;
  typedef enum logic [1:0] {
    OFS_RUN  = 2'd0,
    OFS_CTRL = 2'd1,
    OFS_VSN  = 2'd2,
    OFS_MODE = 2'd3
  } ofs_e;

  typedef enum logic [1:0] {
    SS_NORMAL = 2'd0,
    SS_ZERO   = 2'd1,
    SS_FULL   = 2'd2,
    SS_NORM2  = 2'd3
  } ss_e;

  // switch ON position reads as logic 0
  function automatic logic [7:0] sw_to_bits8(input logic [7:0] sw_on);
    return ~sw_on;
  endfunction

  function automatic logic [4:0] sw_to_bits5(input logic [4:0] sw_on);
    return ~sw_on;
  endfunction

  function automatic logic ss_at_zero(input logic [1:0] code);
    return code == SS_ZERO;
  endfunction

  function automatic logic ss_at_full(input logic [1:0] code);
    return code == SS_FULL;
  endfunction
endpackage

// File: rtl/sio_decode.sv
module sio_decode
  import sio_ctrl_pkg::*;
#(
  parameter int MAIN_W = 8,
  parameter int SUB_W  = 5,
  localparam int ADDR_W = MAIN_W + SUB_W + 3
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        main_sw_on,
  input  logic [4:0]        sub_sw_on,
  output logic              wr_run,
  output logic              wr_ctrl,
  output logic              wr_vsn,
  output logic              wr_mode,
  output logic              rd_stat
);
  logic odd_hit, main_hit, sub_hit, card_hit;
  ofs_e ofs;

  assign odd_hit  = bus_addr[0];
  assign ofs      = ofs_e'(bus_addr[2:1]);
  assign main_hit = bus_addr[ADDR_W-1 -: MAIN_W] == sw_to_bits8(main_sw_on);
  assign sub_hit  = bus_addr[SUB_W+2:3] == sw_to_bits5(sub_sw_on);
  assign card_hit = odd_hit && main_hit && sub_hit;

  assign wr_run  = bus_wr && odd_hit && main_hit && (ofs == OFS_RUN);
  assign wr_ctrl = bus_wr && card_hit && (ofs == OFS_CTRL);
  assign wr_vsn  = bus_wr && card_hit && (ofs == OFS_VSN);
  assign wr_mode = bus_wr && card_hit && (ofs == OFS_MODE);
  assign rd_stat = bus_rd && card_hit && (ofs == OFS_CTRL);
endmodule

// File: rtl/sio_regfile.sv
module sio_regfile
  import sio_ctrl_pkg::*;
#(
  parameter int CH_N = 4,
  localparam int CH_W = $clog2(CH_N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_run,
  input  logic            wr_ctrl,
  input  logic            wr_vsn,
  input  logic            wr_mode,
  input  logic            rd_stat,
  input  logic [7:0]      wdata,
  input  logic            clr_busy,
  output logic            singles_run,
  output logic            coinc_run,
  output logic [CH_W-1:0] sel_chan,
  output logic [1:0]      scale_mode,
  output logic            gate_vme,
  output logic [7:0]      vsn,
  output logic [CH_N-1:0] coinc_en,
  output logic [CH_N-1:0] singles_en,
  output logic            master_rst,
  output logic            mrst_cmd,
  output logic            clr_start,
  output logic [7:0]      rd_data
);
  logic unused_d5;
  logic [7:0] status;

  assign unused_d5 = wdata[5];
  assign mrst_cmd  = wr_ctrl && wdata[6];
  assign clr_start = wr_ctrl && wdata[7] && !wdata[6] && !clr_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      singles_run <= 1'b0;
      coinc_run   <= 1'b0;
      sel_chan    <= '0;
      scale_mode  <= 2'b00;
      gate_vme    <= 1'b0;
      vsn         <= 8'h00;
      coinc_en    <= '0;
      singles_en  <= '0;
      master_rst  <= 1'b0;
    end else if (mrst_cmd) begin
      singles_run <= 1'b0;
      coinc_run   <= 1'b0;
      sel_chan    <= '0;
      scale_mode  <= 2'b00;
      gate_vme    <= 1'b0;
      vsn         <= 8'h00;
      coinc_en    <= '0;
      singles_en  <= '0;
      master_rst  <= 1'b1;
    end else begin
      master_rst <= 1'b0;
      if (wr_run) begin
        singles_run <= wdata[0];
        coinc_run   <= wdata[1];
      end
      if (wr_ctrl) begin
        sel_chan   <= wdata[CH_W-1:0];
        scale_mode <= wdata[3:2];
        gate_vme   <= wdata[4];
      end
      if (wr_vsn)  vsn <= wdata;
      if (wr_mode) begin
        coinc_en   <= wdata[CH_N-1:0];
        singles_en <= wdata[2*CH_N-1:CH_N];
      end
    end
  end

  always_comb begin
    status    = 8'h00;
    status[0] = singles_en[sel_chan];
    status[1] = coinc_en[sel_chan];
    status[2] = ss_at_zero(scale_mode);
    status[3] = ss_at_full(scale_mode);
    status[4] = gate_vme;
    status[7] = clr_busy;
  end

  assign rd_data = rd_stat ? status : 8'h00;
endmodule

// File: rtl/sio_ramclr.sv
module sio_ramclr #(
  parameter int CH_N    = 4,
  parameter int WORD_AW = 12,
  localparam int CH_W   = $clog2(CH_N),
  localparam int RAM_AW = CH_W + WORD_AW,
  localparam logic [WORD_AW-1:0] LAST_IDX = {WORD_AW{1'b1}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [CH_W-1:0]   chan,
  output logic              busy,
  output logic              last_write,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr
);
  logic [WORD_AW-1:0] idx;
  logic [CH_W-1:0]    tgt;

  assign last_write = busy && (idx == LAST_IDX);
  assign ram_we     = busy;
  assign ram_addr   = {tgt, idx};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      tgt  <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
      tgt  <= chan;
    end else if (busy) begin
      if (last_write) busy <= 1'b0;
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/sio_ctrl_regs.sv
module sio_ctrl_regs #(
  parameter int MAIN_W  = 8,
  parameter int SUB_W   = 5,
  parameter int CH_N    = 4,
  parameter int WORD_AW = 12,
  localparam int ADDR_W = MAIN_W + SUB_W + 3,
  localparam int CH_W   = $clog2(CH_N),
  localparam int RAM_AW = CH_W + WORD_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        main_sw_on,
  input  logic [4:0]        sub_sw_on,
  output logic [7:0]        rd_data,
  output logic              singles_run,
  output logic              coinc_run,
  output logic [CH_W-1:0]   sel_chan,
  output logic [1:0]        scale_mode,
  output logic              gate_vme,
  output logic [7:0]        vsn,
  output logic [CH_N-1:0]   coinc_en,
  output logic [CH_N-1:0]   singles_en,
  output logic              master_rst,
  output logic              ram_clr_we,
  output logic [RAM_AW-1:0] ram_clr_addr
);
  // named internal events, visible to the checker
  logic wr_run, wr_ctrl, wr_vsn, wr_mode, rd_stat;
  logic mrst_cmd, clr_start, clr_busy, clr_last;

  sio_decode #(.MAIN_W(MAIN_W), .SUB_W(SUB_W)) u_dec (
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .main_sw_on (main_sw_on),
    .sub_sw_on  (sub_sw_on),
    .wr_run     (wr_run),
    .wr_ctrl    (wr_ctrl),
    .wr_vsn     (wr_vsn),
    .wr_mode    (wr_mode),
    .rd_stat    (rd_stat)
  );

  sio_regfile #(.CH_N(CH_N)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_run      (wr_run),
    .wr_ctrl     (wr_ctrl),
    .wr_vsn      (wr_vsn),
    .wr_mode     (wr_mode),
    .rd_stat     (rd_stat),
    .wdata       (bus_wdata),
    .clr_busy    (clr_busy),
    .singles_run (singles_run),
    .coinc_run   (coinc_run),
    .sel_chan    (sel_chan),
    .scale_mode  (scale_mode),
    .gate_vme    (gate_vme),
    .vsn         (vsn),
    .coinc_en    (coinc_en),
    .singles_en  (singles_en),
    .master_rst  (master_rst),
    .mrst_cmd    (mrst_cmd),
    .clr_start   (clr_start),
    .rd_data     (rd_data)
  );

  sio_ramclr #(.CH_N(CH_N), .WORD_AW(WORD_AW)) u_clr (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (clr_start),
    .abort      (mrst_cmd),
    .chan       (bus_wdata[CH_W-1:0]),
    .busy       (clr_busy),
    .last_write (clr_last),
    .ram_we     (ram_clr_we),
    .ram_addr   (ram_clr_addr)
  );
endmodule

// File: rtl/sio_ctrl_regs_chk.sv
module sio_ctrl_regs_chk #(
  parameter int WORD_AW = 12,
  parameter int RAM_AW  = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_addr0,
  input logic              bus_wr,
  input logic [7:0]        rd_data,
  input logic [7:0]        vsn,
  input logic [3:0]        coinc_en,
  input logic [3:0]        singles_en,
  input logic              singles_run,
  input logic              coinc_run,
  input logic              master_rst,
  input logic              clr_busy,
  input logic              clr_start,
  input logic              ram_we,
  input logic [RAM_AW-1:0] ram_addr
);
  AST_EVEN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_addr0 |=> $stable(vsn) && $stable(coinc_en) && $stable(singles_en)
      && $stable(singles_run) && $stable(coinc_run)); // R1

  AST_STATUS_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[6:5] == 2'b00); // R11

  AST_CLR_FIRST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we) |-> ram_addr[WORD_AW-1:0] == '0); // R8

  AST_CLR_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we && $past(ram_we) |-> ram_addr == $past(ram_addr) + 1'b1); // R8

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_start |=> ram_we && ram_addr[WORD_AW-1:0] == '0); // R9

  AST_MRST_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    master_rst |-> !clr_busy && !singles_run && !coinc_run && vsn == 8'h00
      && coinc_en == 4'h0 && singles_en == 4'h0); // R10

  AST_MRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    master_rst |=> !master_rst); // R10
endmodule

bind sio_ctrl_regs sio_ctrl_regs_chk #(.WORD_AW(WORD_AW), .RAM_AW(RAM_AW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr0   (bus_addr[0]),
  .bus_wr      (bus_wr),
  .rd_data     (rd_data),
  .vsn         (vsn),
  .coinc_en    (coinc_en),
  .singles_en  (singles_en),
  .singles_run (singles_run),
  .coinc_run   (coinc_run),
  .master_rst  (master_rst),
  .clr_busy    (clr_busy),
  .clr_start   (clr_start),
  .ram_we      (ram_clr_we),
  .ram_addr    (ram_clr_addr)
);

// File: tb/sio_ctrl_regs_tb_top.sv
module sio_ctrl_regs_tb_top;
  localparam int WORDS = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  main_sw_on = 8'hF7;   // main address 0x08
  logic [4:0]  sub_sw_on  = 5'b11101; // sub bits 00010 -> base 0x0810
  logic [7:0]  rd_data;
  logic        singles_run, coinc_run, gate_vme, master_rst, ram_clr_we;
  logic [1:0]  sel_chan, scale_mode;
  logic [7:0]  vsn;
  logic [3:0]  coinc_en, singles_en;
  logic [13:0] ram_clr_addr;

  int errors = 0;
  int checks = 0;
  logic [13:0] exp_q[$];

  always #4 clk = ~clk;

  sio_ctrl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .main_sw_on(main_sw_on), .sub_sw_on(sub_sw_on),
    .rd_data(rd_data), .singles_run(singles_run), .coinc_run(coinc_run),
    .sel_chan(sel_chan), .scale_mode(scale_mode), .gate_vme(gate_vme), .vsn(vsn),
    .coinc_en(coinc_en), .singles_en(singles_en), .master_rst(master_rst),
    .ram_clr_we(ram_clr_we), .ram_clr_addr(ram_clr_addr)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = rd_data;
    bus_rd = 1'b0;
  endtask

  // driver side of the scoreboard: expected clear writes
  task automatic push_clear(input logic [1:0] ch);
    for (int i = 0; i < WORDS; i++) exp_q.push_back({ch, 12'(i)});
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (rst_n && ram_clr_we) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8/R10: unexpected clear write addr %h expected none", ram_clr_addr);
      end else begin
        check("R8 clear address", 32'(ram_clr_addr), 32'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("R10 reset vsn", vsn, 8'h00);
    check("R10 reset runs", {singles_run, coinc_run, master_rst, ram_clr_we}, 4'h0);
    bus_read(16'h0813, r); check("R11 reset status", r, 8'h00);

    // R6 station number
    bus_write(16'h0815, 8'hA5); check("R6 vsn load", vsn, 8'hA5);
    // R2 wrong sub / wrong main / inverted polarity
    bus_write(16'h0825, 8'h3C); check("R2 wrong sub ignored", vsn, 8'hA5);
    bus_write(16'h0915, 8'h3C); check("R2 wrong main ignored", vsn, 8'hA5);
    bus_write(16'hF7ED, 8'h3C); check("R2 raw switch value ignored", vsn, 8'hA5);
    // R1 even address
    bus_write(16'h0814, 8'h11); check("R1 even write ignored", vsn, 8'hA5);
    bus_write(16'h0800, 8'h03); check("R1 even run write ignored", {singles_run, coinc_run}, 2'b00);

    // R7 mode select
    bus_write(16'h0817, 8'h53);
    check("R7 coinc enables", coinc_en, 4'h3);
    check("R7 singles enables", singles_en, 4'h5);

    // R3 shared run register, any sub-address
    bus_write(16'h0801, 8'h03); check("R3 both run", {singles_run, coinc_run}, 2'b11);
    bus_write(16'h08F9, 8'h01); check("R3 singles only", {singles_run, coinc_run}, 2'b10);
    bus_write(16'h0901, 8'h00); check("R3 wrong main ignored", {singles_run, coinc_run}, 2'b10);

    // R4 / R5 / R11 control and status
    bus_write(16'h0813, 8'h30); // chan0, normal, vme, D5 set
    check("R4 fields", {sel_chan, scale_mode, gate_vme}, 5'b00_00_1);
    bus_read(16'h0813, r); check("R11 status ch1", r, 8'h13);
    bus_write(16'h0813, 8'h06);
    bus_read(16'h0813, r); check("R5 zero code ch3", r, 8'h05);
    bus_write(16'h0813, 8'h09);
    bus_read(16'h0813, r); check("R5 full code ch2", r, 8'h0A);
    bus_write(16'h0813, 8'h0F);
    check("R4 fields ch4", {sel_chan, scale_mode, gate_vme}, 5'b11_11_0);
    bus_read(16'h0813, r); check("R5 code 11 normal", r, 8'h00);
    bus_read(16'h0815, r); check("R11 non-status read", r, 8'h00);
    bus_read(16'h0812, r); check("R1 even read", r, 8'h00);

    // R8 clear channel 3 (code 10), R9 second start ignored
    push_clear(2'd2);
    bus_write(16'h0813, 8'h82);
    repeat (100) @(negedge clk);
    bus_read(16'h0813, r); check("R8 busy in status", r, 8'h81);
    bus_write(16'h0813, 8'h83);
    check("R9 select updated", sel_chan, 2'd3);
    wait (exp_q.size() == 0);
    bus_read(16'h0813, r); check("R8 busy cleared", r[7], 1'b0);
    repeat (10) @(negedge clk);
    check("R9 no retarget writes", ram_clr_we, 1'b0);

    // R10 master reset aborts a clear
    push_clear(2'd1);
    bus_write(16'h0813, 8'h81);
    repeat (50) @(negedge clk);
    bus_write(16'h0813, 8'h40);
    exp_q.delete();
    check("R10 pulse", master_rst, 1'b1);
    check("R10 regs cleared", {vsn, coinc_en, singles_en, singles_run, coinc_run, gate_vme},
          23'h0);
    @(negedge clk);
    check("R10 pulse ends", master_rst, 1'b0);
    repeat (20) @(negedge clk);
    bus_read(16'h0813, r); check("R10 status after abort", r, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule